// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the lowest layer of an I2C master. It accepts one command at a time: start, write one bit, read one bit, or stop. For each command it drives two open-drain pull-down enables, one for the clock line and one for the data line. Every interval on the bus is a count of system clock cycles, derived from one programmable SCL period. The start and stop conditions, the repeated start, the data hold and setup windows, and the bus-free gap are all covered.

The SCL line is read back through a two-flop synchronizer. The high phase of the clock is counted only while the synchronized line reads high. A slow-rising line, or a slave that holds the clock low, therefore lengthens the bit instead of cutting its high time short. The counts of the high phases are reduced by the two cycles of synchronizer latency. With an ideal line, the released clock then stays high for exactly the intended time.

The surrounding byte controller issues a command while `busy_o` is low and waits for the one-cycle `done_o` pulse. After a read, it takes the sampled bit from `rdata_o`.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is asserted and right after it, both pull-down enables are 0 (lines released), `busy_o` is 0 and `done_o` is 0.
- R2: The effective period P is `period_i` clamped to the range 28..256. The high time is H = floor(P/2) and the low time is L = P - H.
- R3: A start issued on a free bus pulls SDA low while SCL is high. SCL is pulled low exactly H-1 cycles after SDA falls.
- R4: When a start follows a stop, at least H-1 cycles pass between SDA rising at the stop and SDA falling at the start.
- R5: During a command that begins with SCL held low, SDA keeps its level for at least 3 cycles after SCL fell. Any change of SDA lies exactly L-3 cycles before SCL is released.
- R6: For a write or read bit, SCL is held low for at least L cycles. Once the line is seen high, it stays high for exactly H cycles before the engine pulls it low.
- R7: While another device holds SCL low after the engine released it, the engine does not pull SCL. The H-cycle high phase counts from the moment the line actually rises.
- R8: A read bit releases SDA. It captures the synchronized SDA level in the middle of the high phase into `rdata_o`.
- R9: A start issued while the bus is held makes a repeated start. SDA is released during the low phase, and SCL stays high for exactly P cycles before SDA falls. SCL is then pulled low H-1 cycles later.
- R10: A stop drives SDA low during the low phase. SCL is then high for exactly H+2 cycles before SDA is released. After that, both lines are left released.
- R11: Commands use `cmd_op_i` codes 0 = start, 1 = write, 2 = read, 3 = stop. A write, read or stop issued before a start holds the bus is ignored: no busy, no done, and both lines stay released. Any command offered while busy is ignored.
- R12: `busy_o` rises the cycle after a command is accepted and stays high until the command ends. `done_o` is a single-cycle pulse in the cycle where `busy_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | PW | SCL period in system clock cycles (clamped to 28..256) |
| cmd_valid_i | input | 1 | Command strobe, taken when not busy |
| cmd_op_i | input | 2 | Command code: 0 start, 1 write, 2 read, 3 stop |
| cmd_bit_i | input | 1 | Bit value for a write command |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle pulse when a command completes |
| rdata_o | output | 1 | Bit captured by the last read command |
| scl_i | input | 1 | Level of the SCL line (asynchronous) |
| sda_i | input | 1 | Level of the SDA line (asynchronous) |
| scl_pd_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pd_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench goes after periods below 28, above 256, and odd periods. A missing clamp or a wrong half split shows up there as high and low widths that miss H and L. It stretches the clock by several cycles after release. A design that counts from its own release instead of from the observed line would then shorten the visible high phase or pull SCL while a slave still holds it. Repeated starts, back-to-back stops and starts, and data bits whose level changes are timed against P, H+2, H-1 and L-3. Off-by-one counters show up there as an exact-width mismatch. Bit commands issued before any start, and a stop strobed in the middle of a bit, must leave the bus untouched. A design that obeys them would release the bus or pulse `done_o`.

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int PW         = 9,
  parameter int MIN_PERIOD = 28,
  parameter int MAX_PERIOD = 256,
  parameter int HOLD_CYC   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic          cmd_bit_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          rdata_o,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_pd_o,
  output logic          sda_pd_o
);
  localparam int CW = PW + 1;
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_FREE, S_SHOLD, S_DHOLD, S_SETUP, S_HIGH, S_RHIGH, S_PHIGH
  } state_t;

  state_t        state;
  logic [1:0]    op_q;
  logic          bit_q, owned;
  logic          scl_m, scl_s, sda_m, sda_s;
  logic [CW-1:0] per_ext, per, half, low_t, lim, cnt;
  logic          gated, tick, last, take;

  assign per_ext = {1'b0, period_i};
  assign per = (per_ext < CW'(MIN_PERIOD)) ? CW'(MIN_PERIOD) :
               (per_ext > CW'(MAX_PERIOD)) ? CW'(MAX_PERIOD) : per_ext;
  assign half  = per >> 1;
  assign low_t = per - half;

  always_comb begin
    case (state)
      S_FREE, S_SHOLD: lim = half - CW'(1);
      S_DHOLD:         lim = CW'(HOLD_CYC);
      S_SETUP:         lim = low_t - CW'(HOLD_CYC);
      S_HIGH:          lim = half - CW'(2);
      S_RHIGH:         lim = per - CW'(2);
      S_PHIGH:         lim = half;
      default:         lim = CW'(1);
    endcase
  end

  // high phases and the bus-free wait advance only while SCL is seen high
  assign gated  = (state == S_FREE) || (state == S_HIGH) ||
                  (state == S_RHIGH) || (state == S_PHIGH);
  assign tick   = !gated || scl_s;
  assign last   = (state != S_IDLE) && tick && (cnt == lim - CW'(1));
  assign take   = (state == S_IDLE) && cmd_valid_i && (owned || cmd_op_i == OP_START);
  assign busy_o = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
      sda_m <= 1'b1;
      sda_s <= 1'b1;
    end else begin
      scl_m <= scl_i;
      scl_s <= scl_m;
      sda_m <= sda_i;
      sda_s <= sda_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (state == S_IDLE || last) cnt <= '0;
    else if (tick) cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= OP_START;
      bit_q    <= 1'b0;
      owned    <= 1'b0;
      done_o   <= 1'b0;
      rdata_o  <= 1'b0;
      scl_pd_o <= 1'b0;
      sda_pd_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state == S_HIGH && op_q == OP_READ && scl_s && cnt == (lim >> 1))
        rdata_o <= sda_s;
      case (state)
        S_IDLE: if (take) begin
          op_q  <= cmd_op_i;
          bit_q <= cmd_bit_i;
          state <= owned ? S_DHOLD : S_FREE;
        end
        S_FREE: if (last) begin
          sda_pd_o <= 1'b1;
          state    <= S_SHOLD;
        end
        S_SHOLD: if (last) begin
          scl_pd_o <= 1'b1;
          owned    <= 1'b1;
          done_o   <= 1'b1;
          state    <= S_IDLE;
        end
        S_DHOLD: if (last) begin
          case (op_q)
            OP_WRITE: sda_pd_o <= !bit_q;
            OP_STOP:  sda_pd_o <= 1'b1;
            default:  sda_pd_o <= 1'b0;
          endcase
          state <= S_SETUP;
        end
        S_SETUP: if (last) begin
          scl_pd_o <= 1'b0;
          state    <= (op_q == OP_START) ? S_RHIGH :
                      (op_q == OP_STOP)  ? S_PHIGH : S_HIGH;
        end
        S_HIGH: if (last) begin
          scl_pd_o <= 1'b1;
          done_o   <= 1'b1;
          state    <= S_IDLE;
        end
        S_RHIGH: if (last) begin
          sda_pd_o <= 1'b1;
          state    <= S_SHOLD;
        end
        S_PHIGH: if (last) begin
          sda_pd_o <= 1'b0;
          owned    <= 1'b0;
          done_o   <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid_i,
  input logic [1:0] cmd_op_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       scl_i,
  input logic       scl_pd_o,
  input logic       sda_pd_o
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R11
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !cmd_valid_i) |=> ($stable(scl_pd_o) && $stable(sda_pd_o)));

  // R11
  unowned_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_valid_i && cmd_op_i != 2'd0 && !scl_pd_o) |=> !busy_o);

  // R5
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pd_o) |=> $stable(sda_pd_o));

  // R7
  no_pull_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pd_o && !scl_i) |=> !scl_pd_o);
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .busy_o(busy_o), .done_o(done_o), .scl_i(scl_i),
  .scl_pd_o(scl_pd_o), .sda_pd_o(sda_pd_o)
);

// File: tb/test_i2c_bit_engine.sv
module test_i2c_bit_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [8:0] period = 9'd100;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_bit = 1'b0;
  logic       busy, done, rdata, scl_pd, sda_pd;
  logic       slv_sda_pd = 1'b0;
  int         stretch_left = 0;
  int         stretch_amt = 0;
  logic       scl_line, sda_line;

  assign scl_line = !scl_pd && (stretch_left == 0);
  assign sda_line = !sda_pd && !slv_sda_pd;

  i2c_bit_engine i_i2c_bit_engine (
    .clk(clk), .rst_n(rst_n), .period_i(period), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_bit_i(cmd_bit), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pd_o(scl_pd), .sda_pd_o(sda_pd)
  );

  int total = 0, bad = 0, cyc = 0;
  int T = 100, H = 50, L = 50;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_period(int p);
    if (p < 28) return 28;
    if (p > 256) return 256;
    return p;
  endfunction

  task automatic set_period(int p);
    period = 9'(p);
    T = eff_period(p);
    H = T / 2;
    L = T - H;
  endtask

  // bus monitor, sampled on the falling edge
  logic prev_sp = 0, prev_dp = 0, prev_sl = 1;
  int   hi_start = 0, low_start = 0, sda_chg = 0, sfall = 0, last_stop = 0;
  bit   chg_in_low = 0, have_stop = 0, bus_active = 0, stretched = 0;
  int   cond_kind = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic sp, dp, sl;
      sp = scl_pd;
      dp = sda_pd;
      if (!sp && prev_sp) begin
        stretch_left = stretch_amt;
        stretched = (stretch_amt > 0);
      end else if (stretch_left > 0) stretch_left--;
      sl = !sp && (stretch_left == 0);
      if (sl && !prev_sl) hi_start = cyc;
      if (dp && !prev_dp && sl) begin
        if (!bus_active) begin
          if (have_stop) chk(cyc - last_stop >= H - 1, "R4 bus free", cyc - last_stop, H - 1);
          cond_kind = 1;
        end else begin
          chk(cyc - hi_start == T, "R9 repeated start high", cyc - hi_start, T);
          cond_kind = 2;
        end
        sfall = cyc;
        bus_active = 1;
      end
      if (!dp && prev_dp && sl && !sp) begin
        chk(cyc - hi_start == H + 2, "R10 stop setup", cyc - hi_start, H + 2);
        last_stop = cyc;
        have_stop = 1;
        bus_active = 0;
      end
      if (sp && !prev_sp) begin
        if (cond_kind == 1)
          chk(cyc - sfall == H - 1, "R3 start hold", cyc - sfall, H - 1);
        else if (cond_kind == 2)
          chk(cyc - sfall == H - 1, "R9 start hold", cyc - sfall, H - 1);
        else if (stretched)
          chk(cyc - hi_start == H, "R7 stretched high", cyc - hi_start, H);
        else
          chk(cyc - hi_start == H, "R6 R2 high width", cyc - hi_start, H);
        cond_kind = 0;
        low_start = cyc;
        chg_in_low = 0;
      end
      if (dp != prev_dp && sp) begin
        chk(cyc - low_start >= 3, "R5 hold", cyc - low_start, 3);
        sda_chg = cyc;
        chg_in_low = 1;
      end
      if (!sp && prev_sp) begin
        chk(cyc - low_start >= L, "R6 R2 low width", cyc - low_start, L);
        if (chg_in_low) chk(cyc - sda_chg == L - 3, "R5 setup", cyc - sda_chg, L - 3);
      end
      prev_sp = sp;
      prev_dp = dp;
      prev_sl = sl;
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // inject: strobe a stop in the middle of the command (R11)
  task automatic do_cmd(int op, bit b, int st, bit inject, output bit rd);
    int n;
    @(negedge clk);
    stretch_amt = st;
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_bit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R12 busy after accept", int'(busy), 1);
    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
      if (inject && n == 5) begin
        cmd_valid = 1'b1;
        cmd_op = 2'd3;
      end else cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    chk(done == 1'b1, "R12 done seen", int'(done), 1);
    chk(busy == 1'b0, "R12 busy low with done", int'(busy), 0);
    rd = rdata;
    @(negedge clk);
    chk(done == 1'b0, "R12 done single cycle", int'(done), 0);
    stretch_amt = 0;
  endtask

  task automatic rd_bit(bit v, int st);
    bit r;
    slv_sda_pd = !v;
    do_cmd(2, 1'b0, st, 0, r);
    slv_sda_pd = 1'b0;
    chk(r == v, "R8 read data", int'(r), int'(v));
  endtask

  task automatic ignored(int op);
    bit seen;
    seen = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_bit = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) begin
      if (busy || done || scl_pd || sda_pd) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R11 ignored without start", int'(seen), 0);
  endtask

  task automatic transaction(int p, int nbits, bit rs);
    bit r;
    set_period(p);
    do_cmd(0, 0, 0, 0, r);
    for (int i = 0; i < nbits; i++) begin
      int st;
      st = int'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) rd_bit(1'($urandom_range(0, 1)), st);
      else do_cmd(1, 1'($urandom_range(0, 1)), st, 0, r);
    end
    if (rs) begin
      do_cmd(0, 0, int'($urandom_range(0, 3)), 0, r);
      do_cmd(1, 1'($urandom_range(0, 1)), 0, 0, r);
    end
    do_cmd(3, 0, int'($urandom_range(0, 3)), 0, r);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    bit r;
    void'($urandom(32'h5eed));
    set_period(100);
    repeat (3) @(negedge clk);
    chk({scl_pd, sda_pd, busy, done} == 4'b0, "R1 in reset", int'({scl_pd, sda_pd, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({scl_pd, sda_pd, busy, done} == 4'b0, "R1 after reset", int'({scl_pd, sda_pd, busy, done}), 0);

    ignored(1);
    ignored(2);
    ignored(3);

    // directed transaction, period 100
    do_cmd(0, 0, 0, 0, r);
    chk(scl_pd && sda_pd, "R3 bus held after start", int'({scl_pd, sda_pd}), 3);
    do_cmd(1, 1, 0, 0, r);
    do_cmd(1, 0, 0, 0, r);
    do_cmd(1, 1, 0, 1, r);
    chk(scl_pd == 1'b1, "R11 stop while busy ignored", int'(scl_pd), 1);
    rd_bit(0, 0);
    rd_bit(1, 0);
    rd_bit(0, 5);
    do_cmd(0, 0, 0, 0, r);
    do_cmd(1, 0, 6, 0, r);
    do_cmd(3, 0, 0, 0, r);
    chk(!scl_pd && !sda_pd && !busy, "R10 bus released after stop", int'({scl_pd, sda_pd}), 0);

    // clamp and odd-period corners
    transaction(10, 3, 0);
    transaction(27, 2, 1);
    transaction(300, 2, 0);
    transaction(257, 2, 1);
    transaction(101, 3, 1);
    transaction(28, 4, 0);

    // constrained random
    for (int k = 0; k < 12; k++)
      transaction(int'($urandom_range(20, 280)), int'($urandom_range(1, 9)), 1'($urandom_range(0, 1)));

    repeat (10) @(negedge clk);
    finish_up();
  end
endmodule